// File: doc/BRIEF.md
# Global Interrupt Status Register for a Dual-Role Serial Bus Controller

This block holds the top-level interrupt status word of a serial bus controller that can run as host or as device. Three event bits are sticky: they latch single-cycle event pulses and stay set until software writes 1 to them. Three more bits are read-only summaries. Each is computed every cycle from a lower-level source: the per-channel interrupt flags, the port-change flag, and the fill level of the periodic transmit FIFO together with the space left in its request queue. A summary bit can only be cleared at its source, never by a write to this register. One bit reports the current operating mode.

Software reaches the block through a small register port that selects either the status word or a mask word. Reads are combinational and writes take effect at the clock edge. The interrupt output is high whenever any status bit is set and the matching mask bit is enabled. Events that only make sense in host mode are dropped while the controller runs as a device.

Top module: `usb_gint_status`

## Requirements
- R1: Bit 31 (wakeup) is sticky. It sets on `resume_i` while `host_mode_i`=0 and on `rmt_wkup_i` while `host_mode_i`=1. The input that belongs to the other mode is ignored. Writing 1 to bit 31 of the status word (`reg_sel_i`=0) clears it.
- R2: Bit 29 (disconnect) is sticky and is cleared by writing 1. It sets on `disc_i` only while `host_mode_i`=1. In device mode the pulse leaves bit 29 at 0.
- R3: Bit 28 (connector ID change) is sticky and is cleared by writing 1. It sets in either mode when `conn_id_i` differs from its value in the previous cycle. The first cycle after reset only samples `conn_id_i` and does not set the bit.
- R4: When a set event and a write-1 clear hit the same sticky bit in the same cycle, the bit ends up set.
- R5: Bit 26 (periodic TX empty) is read-only. It is 1 only when `ptxq_space_i`=1 and the FIFO level condition is met. With `ptx_full_sel_i`=0 the condition is 2*`ptx_free_i` >= PTX_DEPTH (half empty). With `ptx_full_sel_i`=1 it is `ptx_free_i` == PTX_DEPTH (completely empty).
- R6: Bit 25 (channel summary) equals the OR of all bits of `ch_irq_i`. Writes to it have no effect.
- R7: Bit 24 (port summary) follows `port_chg_i`. Writes to it have no effect.
- R8: Bits 30 and 27, and every other bit not named in these requirements, read 0 and ignore writes.
- R9: Bit 0 of the status word reads `host_mode_i` (1 = host, 0 = device).
- R10: Writing with `reg_sel_i`=1 loads the mask with `reg_wdata_i` & 32'hB700_0000, and the mask reads back at `reg_sel_i`=1. `irq_o` = OR of (status & mask).
- R11: After reset the sticky bits and the mask are 0. With the FIFO empty and the queue having space, the status word then reads 32'h0400_0000 in device mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_mode_i | input | 1 | 1 = host mode, 0 = device mode |
| resume_i | input | 1 | Pulse: resume seen from host (device mode event) |
| rmt_wkup_i | input | 1 | Pulse: remote wakeup seen from device (host mode event) |
| disc_i | input | 1 | Pulse: device disconnect (host mode event) |
| conn_id_i | input | 1 | Connector ID level |
| ch_irq_i | input | NUM_CH | Per-channel pending interrupt flags |
| port_chg_i | input | 1 | Port status change flag |
| ptx_free_i | input | PTX_W | Free words in the periodic TX FIFO |
| ptx_full_sel_i | input | 1 | Empty threshold: 0 = half, 1 = completely |
| ptxq_space_i | input | 1 | Periodic request queue has room |
| reg_sel_i | input | 1 | 0 = status word, 1 = mask word |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for the selected word |
| irq_o | output | 1 | Combined masked interrupt |

## Verification
The critical overlap is a sticky event pulse landing in the same cycle as a software write-1 clear of that same bit. It is provoked directly for the wakeup, disconnect and connector-ID bits, and random stimulus produces it again many times. The bench judges it from the read value one edge later: the bit must still be set, as the R4 rule requires. A second overlap is a write of all ones to the status word while the summary bits are held high. The bench expects those summary bits to stay at the value their sources give.

// File: rtl/usb_gint_pkg.sv
package usb_gint_pkg;
  localparam int DATA_W   = 32;
  localparam int BIT_WKUP = 31;
  localparam int BIT_DISC = 29;
  localparam int BIT_CIDC = 28;
  localparam int BIT_PTXE = 26;
  localparam int BIT_HCH  = 25;
  localparam int BIT_PORT = 24;
  localparam int BIT_MODE = 0;

  localparam int N_STICKY  = 3;
  localparam int SIDX_WKUP = 0;
  localparam int SIDX_DISC = 1;
  localparam int SIDX_CIDC = 2;

  localparam logic [DATA_W-1:0] IRQ_BITS =
      (DATA_W'(1) << BIT_WKUP) | (DATA_W'(1) << BIT_DISC) | (DATA_W'(1) << BIT_CIDC) |
      (DATA_W'(1) << BIT_PTXE) | (DATA_W'(1) << BIT_HCH)  | (DATA_W'(1) << BIT_PORT);

  typedef enum logic {
    SEL_STAT = 1'b0,
    SEL_MASK = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/gint_sticky_bank.sv
module gint_sticky_bank #(
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q_o[i] <= 1'b0;
      else if (set_i[i]) q_o[i] <= 1'b1;  // set beats clear
      else if (clr_i[i]) q_o[i] <= 1'b0;
    end

    p_set_wins_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[i] |=> q_o[i]);
    p_w1c_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[i] && !set_i[i]) |=> !q_o[i]);
    p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!clr_i[i] && !set_i[i]) |=> $stable(q_o[i]));
  end
endmodule

// File: rtl/gint_ptx_level.sv
module gint_ptx_level #(
  parameter int DEPTH = 64,
  parameter int W     = $clog2(DEPTH + 1)
) (
  input  logic [W-1:0] free_i,
  input  logic         full_sel_i,
  input  logic         qspace_i,
  output logic         empty_o
);
  localparam logic [W:0]   DEPTH_X = (W+1)'(DEPTH);
  localparam logic [W-1:0] DEPTH_N = W'(DEPTH);

  logic half_ok, full_ok;

  always_comb begin
    half_ok = {free_i, 1'b0} >= DEPTH_X;
    full_ok = free_i == DEPTH_N;
    empty_o = qspace_i && (full_sel_i ? full_ok : half_ok);
  end

  always_comb begin
    if (!qspace_i) p_no_queue_r5: assert (!empty_o);
    if (full_ok)   p_full_implies_half_r5: assert (half_ok);
  end
endmodule

// File: rtl/usb_gint_status.sv
module usb_gint_status
  import usb_gint_pkg::*;
#(
  parameter int NUM_CH    = 8,
  parameter int PTX_DEPTH = 64,
  parameter int PTX_W     = $clog2(PTX_DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_mode_i,
  input  logic              resume_i,
  input  logic              rmt_wkup_i,
  input  logic              disc_i,
  input  logic              conn_id_i,
  input  logic [NUM_CH-1:0] ch_irq_i,
  input  logic              port_chg_i,
  input  logic [PTX_W-1:0]  ptx_free_i,
  input  logic              ptx_full_sel_i,
  input  logic              ptxq_space_i,
  input  logic              reg_sel_i,
  input  logic              reg_wr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o
);
  reg_sel_e sel;
  logic [N_STICKY-1:0] st_set, st_clr, st_q;
  logic [DATA_W-1:0]   status, mask_q;
  logic                conn_q, seen_q, cid_chg, ptx_empty, wr_stat;

  assign sel     = reg_sel_e'(reg_sel_i);
  assign wr_stat = reg_wr_i && (sel == SEL_STAT);

  // connector ID edge detect; first cycle after reset only samples
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      conn_q <= 1'b0;
      seen_q <= 1'b0;
    end else begin
      conn_q <= conn_id_i;
      seen_q <= 1'b1;
    end
  end
  assign cid_chg = seen_q && (conn_id_i != conn_q);

  always_comb begin
    st_set            = '0;
    st_set[SIDX_WKUP] = host_mode_i ? rmt_wkup_i : resume_i;
    st_set[SIDX_DISC] = host_mode_i && disc_i;
    st_set[SIDX_CIDC] = cid_chg;
    st_clr            = '0;
    st_clr[SIDX_WKUP] = wr_stat && reg_wdata_i[BIT_WKUP];
    st_clr[SIDX_DISC] = wr_stat && reg_wdata_i[BIT_DISC];
    st_clr[SIDX_CIDC] = wr_stat && reg_wdata_i[BIT_CIDC];
  end

  gint_sticky_bank #(.N(N_STICKY)) u_sticky (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (st_set),
    .clr_i  (st_clr),
    .q_o    (st_q)
  );

  gint_ptx_level #(.DEPTH(PTX_DEPTH), .W(PTX_W)) u_ptx (
    .free_i     (ptx_free_i),
    .full_sel_i (ptx_full_sel_i),
    .qspace_i   (ptxq_space_i),
    .empty_o    (ptx_empty)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          mask_q <= '0;
    else if (reg_wr_i && sel == SEL_MASK) mask_q <= reg_wdata_i & IRQ_BITS;
  end

  always_comb begin
    status           = '0;
    status[BIT_WKUP] = st_q[SIDX_WKUP];
    status[BIT_DISC] = st_q[SIDX_DISC];
    status[BIT_CIDC] = st_q[SIDX_CIDC];
    status[BIT_PTXE] = ptx_empty;
    status[BIT_HCH]  = |ch_irq_i;
    status[BIT_PORT] = port_chg_i;
    status[BIT_MODE] = host_mode_i;
  end

  assign reg_rdata_o = (sel == SEL_MASK) ? mask_q : status;
  assign irq_o       = |(status & mask_q);

  p_disc_dev_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!host_mode_i && !st_q[SIDX_DISC]) |=> !st_q[SIDX_DISC]);
  p_wkup_dev_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!host_mode_i && !resume_i && !st_q[SIDX_WKUP]) |=> !st_q[SIDX_WKUP]);
  p_mask_legal_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q & ~IRQ_BITS) == '0);
  p_irq_needs_mask_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (mask_q != '0));
  p_hch_summary_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel == SEL_STAT && (|ch_irq_i)) |-> reg_rdata_o[BIT_HCH]);
endmodule

// File: tb/tb_usb_gint_status.sv
module tb_usb_gint_status;
  localparam int NUM_CH = 8;
  localparam int DEPTH  = 64;
  localparam int W      = $clog2(DEPTH + 1);
  localparam logic [31:0] IRQM = 32'hB700_0000;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic host_mode_i = 0, resume_i = 0, rmt_wkup_i = 0, disc_i = 0, conn_id_i = 0;
  logic [NUM_CH-1:0] ch_irq_i = '0;
  logic port_chg_i = 0, ptx_full_sel_i = 0, ptxq_space_i = 1;
  logic [W-1:0] ptx_free_i = W'(DEPTH);
  logic reg_sel_i = 0, reg_wr_i = 0;
  logic [31:0] reg_wdata_i = '0, reg_rdata_o;
  logic irq_o;

  int n_chk = 0, n_bad = 0;
  logic m_wk = 0, m_dc = 0, m_ci = 0, m_prev = 0, m_seen = 0;
  logic [31:0] m_mask = '0;
  logic done = 0;

  always #5 clk_i = ~clk_i;

  usb_gint_status #(.NUM_CH(NUM_CH), .PTX_DEPTH(DEPTH)) dut (.*);

  function automatic logic [31:0] exp_word();
    logic [31:0] w = '0;
    w[31] = m_wk; w[29] = m_dc; w[28] = m_ci;
    w[26] = ptxq_space_i && (ptx_full_sel_i ? (int'(ptx_free_i) == DEPTH)
                                            : (2 * int'(ptx_free_i) >= DEPTH));
    w[25] = |ch_irq_i;
    w[24] = port_chg_i;
    w[0]  = host_mode_i;
    return w;
  endfunction

  task automatic check(string tag);
    logic [31:0] er = reg_sel_i ? m_mask : exp_word();
    logic ei = |(exp_word() & m_mask);
    n_chk += 2;
    if (reg_rdata_o !== er) begin
      n_bad++; $display("FAIL %s rdata got %h exp %h", tag, reg_rdata_o, er);
    end
    if (irq_o !== ei) begin
      n_bad++; $display("FAIL %s irq got %b exp %b", tag, irq_o, ei);
    end
  endtask

  task automatic model_edge();
    logic sw = host_mode_i ? rmt_wkup_i : resume_i;
    logic sd = host_mode_i && disc_i;
    logic sc = m_seen && (conn_id_i != m_prev);
    logic wst = reg_wr_i && !reg_sel_i;
    m_wk = sw | (m_wk & ~(wst & reg_wdata_i[31]));
    m_dc = sd | (m_dc & ~(wst & reg_wdata_i[29]));
    m_ci = sc | (m_ci & ~(wst & reg_wdata_i[28]));
    m_prev = conn_id_i; m_seen = 1;
    if (reg_wr_i && reg_sel_i) m_mask = reg_wdata_i & IRQM;
  endtask

  // inputs are set at a falling edge; check, then let one rising edge pass
  task automatic step(string tag);
    #1 check(tag);
    @(posedge clk_i); model_edge();
    @(negedge clk_i);
    resume_i = 0; rmt_wkup_i = 0; disc_i = 0; reg_wr_i = 0; reg_wdata_i = '0;
  endtask

  task automatic wr(logic sel, logic [31:0] d);
    reg_sel_i = sel; reg_wr_i = 1; reg_wdata_i = d;
  endtask

  initial begin
    #500000;
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    #1 check("R11 reset status");
    reg_sel_i = 1; #1 check("R11 reset mask"); reg_sel_i = 0;
    @(negedge clk_i); @(negedge clk_i); rst_ni = 1;
    step("R11 after reset");
    // R1 device resume, host remote wakeup, wrong-mode input ignored
    resume_i = 1; step("R1 dev resume");
    step("R1 dev set");
    wr(0, 32'h8000_0000); step("R1 w1c");
    step("R1 cleared");
    host_mode_i = 1; resume_i = 1; step("R9 host mode bit");
    step("R1 host ignores resume");
    rmt_wkup_i = 1; step("R1 host rwkup");
    step("R1 host set");
    wr(0, 32'h8000_0000); step("R1 host w1c");
    // R2
    disc_i = 1; step("R2 host disc");
    step("R2 set");
    wr(0, 32'h2000_0000); step("R2 w1c");
    host_mode_i = 0; disc_i = 1; step("R2 dev disc");
    step("R2 dev ignored");
    // R3 both edges
    conn_id_i = 1; step("R3 rise");
    step("R3 set");
    wr(0, 32'h1000_0000); step("R3 w1c");
    conn_id_i = 0; step("R3 fall");
    step("R3 set again");
    // R4 same-cycle set and clear
    resume_i = 1; wr(0, 32'hB000_0000); step("R4 wkup collide");
    step("R4 wkup kept");
    host_mode_i = 1; disc_i = 1; conn_id_i = 1; wr(0, 32'hFFFF_FFFF); step("R4 disc cid collide");
    step("R4 kept");
    wr(0, 32'hFFFF_FFFF); step("R4 clear all");
    // R5 thresholds
    ptx_full_sel_i = 0; ptx_free_i = W'(DEPTH / 2);     step("R5 half at limit");
    ptx_free_i = W'(DEPTH / 2 - 1);                     step("R5 below half");
    ptx_full_sel_i = 1; ptx_free_i = W'(DEPTH - 1);     step("R5 full not met");
    ptx_free_i = W'(DEPTH);                             step("R5 full met");
    ptxq_space_i = 0;                                   step("R5 no queue space");
    ptxq_space_i = 1;
    // R6 R7 R8 write attempts on read-only and reserved bits
    ch_irq_i = 8'h80; port_chg_i = 1; wr(0, 32'h4B00_0000); step("R6 R7 write");
    step("R6 hch held");
    step("R7 port held");
    ch_irq_i = '0; port_chg_i = 0; wr(0, 32'hFFFF_FFFF); step("R8 reserved write");
    step("R8 reserved zero");
    // R10 mask
    wr(1, 32'hFFFF_FFFF); step("R10 mask write");
    reg_sel_i = 1; step("R10 mask read");
    reg_sel_i = 0; ptxq_space_i = 0; step("R10 irq off");
    ch_irq_i = 8'h01; step("R10 irq via hch");
    wr(1, 32'h0200_0000); step("R10 mask narrow");
    ch_irq_i = '0; step("R10 irq drops");
    // random mix
    for (int i = 0; i < 4000; i++) begin
      host_mode_i    = ($urandom % 8) != 0 ? host_mode_i : ~host_mode_i;
      resume_i       = ($urandom % 5) == 0;
      rmt_wkup_i     = ($urandom % 5) == 0;
      disc_i         = ($urandom % 5) == 0;
      conn_id_i      = ($urandom % 6) == 0 ? ~conn_id_i : conn_id_i;
      ch_irq_i       = ($urandom % 3) == 0 ? NUM_CH'($urandom) : '0;
      port_chg_i     = ($urandom % 4) == 0;
      ptx_free_i     = W'($urandom % (DEPTH + 1));
      ptx_full_sel_i = $urandom % 2;
      ptxq_space_i   = ($urandom % 4) != 0;
      reg_sel_i      = ($urandom % 4) == 0;
      reg_wr_i       = ($urandom % 3) == 0;
      reg_wdata_i    = $urandom;
      step("RND");
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule